// File: doc/BRIEF.md
# Peripheral Test Instruction Responder

This block is the device-side half of the processor's test-a-unit handshake. The processor first raises an instruction sync strobe with the unit number on the unit lines and the test decode line active. If the unit number is this device's own, the block answers with a sync return on the next clock. This instruction is never held back: the device is treated as ready at all times, and no wait behaviour exists.

The processor then raises its data-here strobe with the second instruction word on the bus. The block compares the function field of that word with a vector of local status conditions. It raises the test return, which tells the processor to skip, when at least one selected condition is present. It always raises the data-accepted line, and both lines change on the same clock.

Each return line clears one clock after the processor drops the strobe that caused it. A data-here strobe that does not follow this device's own sync handshake is ignored. What each status bit means is left to the surrounding peripheral.

Top module: `ptr_test_responder`

## Requirements
- R1: While reset is asserted, the sync return, test return and data-accepted outputs are all low.
- R2: When instruction sync is high, the test decode is high and the unit lines equal UNIT_ID at a clock edge, the sync return is high after that edge. No readiness condition applies.
- R3: If the unit lines differ from UNIT_ID, or the test decode is low, instruction sync does not raise the sync return.
- R4: The sync return goes low on the first clock edge at which instruction sync is low.
- R5: After the device has returned sync, the first clock edge with data-here high sets data-accepted. This happens whatever the test result is.
- R6: The test return is set on that same edge only when the function field AND the status vector is nonzero. The function field is bus bits FUNC_LSB to FUNC_LSB+FUNC_W-1, and field bit i pairs with status bit i. Bus bits outside the field have no effect.
- R7: Test return and data-accepted both go low on the first clock edge at which data-here is low.
- R8: The test return is never high while data-accepted is low.
- R9: While data-here stays high, the test result stays as captured on the first edge. Later changes to the bus or the status vector do not change it.
- R10: A data-here strobe with no preceding sync handshake to this device leaves data-accepted and test return low.
- R11: A completed data phase disarms the device. A further data-here strobe needs a new sync handshake first, or it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inst_sync_i | input | 1 | Instruction sync strobe from the processor |
| test_dec_i | input | 1 | Test instruction decode from the processor |
| unit_sel_i | input | UNIT_W | Unit number presented by the processor |
| data_here_i | input | 1 | Data-here strobe from the processor |
| io_word_i | input | DATA_W | Second instruction word on the I/O bus |
| cond_i | input | FUNC_W | Local status conditions |
| sync_ret_o | output | 1 | Sync return to the processor |
| test_ret_o | output | 1 | Test return (skip request) to the processor |
| data_ack_o | output | 1 | Data-accepted return to the processor |

## Verification
The comparison is driven with pairs of function field and status vector. The pairs include disjoint patterns, a single shared bit at either end of the field, several shared bits, an empty function field and an empty status vector. These show whether the AND-then-OR rule is right and whether any field bit is dropped or misaligned. The bits above the field hold a fixed nonzero pattern in every pair, so a design that reads outside the field gives a wrong skip result. Directed cases then cover a wrong unit and a missing test decode, a data-here strobe with no sync, a repeated data-here after a completed phase, and a status change while data-here is held. Together they separate the handshake sequencing from the comparison itself.

// File: rtl/ptr_pkg.sv
package ptr_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ARMED = 2'd1,
      PH_DATA  = 2'd2
   } ptr_phase_e;

endpackage

// File: rtl/ptr_unit_decode.sv
module ptr_unit_decode #(
   parameter int UNIT_W  = 6,
   parameter int UNIT_ID = 9
) (
   input  logic              inst_sync_i,
   input  logic              test_dec_i,
   input  logic [UNIT_W-1:0] unit_sel_i,
   output logic              hit_o
);
   localparam logic [UNIT_W-1:0] MY_UNIT = UNIT_ID[UNIT_W-1:0];

   logic addr_eq;

   assign addr_eq = (unit_sel_i == MY_UNIT);
   assign hit_o   = inst_sync_i & test_dec_i & addr_eq;

endmodule

// File: rtl/ptr_cond_match.sv
module ptr_cond_match #(
   parameter int DATA_W   = 16,
   parameter int FUNC_W   = 8,
   parameter int FUNC_LSB = 0
) (
   input  logic [DATA_W-1:0] io_word_i,
   input  logic [FUNC_W-1:0] cond_i,
   output logic              match_o
);
   logic [FUNC_W-1:0] per_bit;
   logic              unused_word;

   for (genvar i = 0; i < FUNC_W; i++) begin : g_bit
      assign per_bit[i] = io_word_i[FUNC_LSB + i] & cond_i[i];
   end

   assign match_o     = |per_bit;
   assign unused_word = ^io_word_i;

endmodule

// File: rtl/ptr_phase_ctl.sv
module ptr_phase_ctl
   import ptr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hit_i,
   input  logic data_here_i,
   input  logic match_i,
   output logic sync_ret_o,
   output logic test_ret_o,
   output logic data_ack_o
);
   ptr_phase_e phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_ret_o <= 1'b0;
      end else begin
         sync_ret_o <= hit_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         test_ret_o <= 1'b0;
         data_ack_o <= 1'b0;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               if (hit_i) phase_q <= PH_ARMED;
            end
            PH_ARMED: begin
               if (data_here_i) begin
                  phase_q    <= PH_DATA;
                  data_ack_o <= 1'b1;
                  test_ret_o <= match_i;
               end
            end
            PH_DATA: begin
               if (!data_here_i) begin
                  phase_q    <= PH_IDLE;
                  data_ack_o <= 1'b0;
                  test_ret_o <= 1'b0;
               end
            end
            default: begin
               phase_q    <= PH_IDLE;
               data_ack_o <= 1'b0;
               test_ret_o <= 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/ptr_test_responder.sv
module ptr_test_responder #(
   parameter int UNIT_W   = 6,
   parameter int UNIT_ID  = 9,
   parameter int DATA_W   = 16,
   parameter int FUNC_W   = 8,
   parameter int FUNC_LSB = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inst_sync_i,
   input  logic              test_dec_i,
   input  logic [UNIT_W-1:0] unit_sel_i,
   input  logic              data_here_i,
   input  logic [DATA_W-1:0] io_word_i,
   input  logic [FUNC_W-1:0] cond_i,
   output logic              sync_ret_o,
   output logic              test_ret_o,
   output logic              data_ack_o
);
   localparam int FIELD_TOP = FUNC_LSB + FUNC_W;

   if (UNIT_W < 1 || UNIT_W > 16) begin : g_bad_unit_w
      $error("ptr_test_responder: UNIT_W out of range");
   end
   if (UNIT_ID < 0 || UNIT_ID >= (1 << UNIT_W)) begin : g_bad_unit_id
      $error("ptr_test_responder: UNIT_ID does not fit UNIT_W");
   end
   if (FUNC_W < 1 || FUNC_LSB < 0 || FIELD_TOP > DATA_W) begin : g_bad_field
      $error("ptr_test_responder: function field outside bus word");
   end

   logic hit;
   logic match;

   ptr_unit_decode #(
      .UNIT_W  (UNIT_W),
      .UNIT_ID (UNIT_ID)
   ) u_decode (
      .inst_sync_i (inst_sync_i),
      .test_dec_i  (test_dec_i),
      .unit_sel_i  (unit_sel_i),
      .hit_o       (hit)
   );

   ptr_cond_match #(
      .DATA_W   (DATA_W),
      .FUNC_W   (FUNC_W),
      .FUNC_LSB (FUNC_LSB)
   ) u_match (
      .io_word_i (io_word_i),
      .cond_i    (cond_i),
      .match_o   (match)
   );

   ptr_phase_ctl u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit_i       (hit),
      .data_here_i (data_here_i),
      .match_i     (match),
      .sync_ret_o  (sync_ret_o),
      .test_ret_o  (test_ret_o),
      .data_ack_o  (data_ack_o)
   );

endmodule

// File: rtl/ptr_test_responder_chk.sv
module ptr_test_responder_chk #(
   parameter int UNIT_W  = 6,
   parameter int UNIT_ID = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              inst_sync_i,
   input logic              test_dec_i,
   input logic [UNIT_W-1:0] unit_sel_i,
   input logic              data_here_i,
   input logic              sync_ret_o,
   input logic              test_ret_o,
   input logic              data_ack_o
);
   localparam logic [UNIT_W-1:0] ME = UNIT_ID[UNIT_W-1:0];

   // R2: own selected sync yields sync return on the next edge
   p_sync_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (inst_sync_i && test_dec_i && unit_sel_i == ME) |=> sync_ret_o);

   // R3: a foreign unit number never produces a sync return
   p_foreign_unit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_sel_i != ME) |=> !sync_ret_o);

   // R4: removing sync drops the sync return
   p_sync_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !inst_sync_i |=> !sync_ret_o);

   // R5: data-accepted only rises in answer to data-here
   p_ack_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_ack_o) |-> $past(data_here_i));

   // R7: removing data-here clears both data-phase returns
   p_data_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !data_here_i |=> (!test_ret_o && !data_ack_o));

   // R8: test return only alongside data-accepted
   p_test_with_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      test_ret_o |-> data_ack_o);

   // R9: result held while data-here persists
   p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (data_ack_o && data_here_i) |=> $stable(test_ret_o));

endmodule

bind ptr_test_responder ptr_test_responder_chk #(
   .UNIT_W  (UNIT_W),
   .UNIT_ID (UNIT_ID)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .inst_sync_i (inst_sync_i),
   .test_dec_i  (test_dec_i),
   .unit_sel_i  (unit_sel_i),
   .data_here_i (data_here_i),
   .sync_ret_o  (sync_ret_o),
   .test_ret_o  (test_ret_o),
   .data_ack_o  (data_ack_o)
);

// File: tb/ptr_test_responder_tb.sv
module ptr_test_responder_tb;
   localparam int CLK_P   = 10;
   localparam int UNIT_W  = 6;
   localparam int UNIT_ID = 9;
   localparam int DATA_W  = 16;
   localparam int FUNC_W  = 8;
   localparam int NVEC    = 9;

   // {function field, status vector, expected test return}
   localparam logic [16:0] VEC [NVEC] = '{
      {8'h00, 8'hFF, 1'b0},
      {8'h01, 8'h01, 1'b1},
      {8'h80, 8'h7F, 1'b0},
      {8'h80, 8'h80, 1'b1},
      {8'hF0, 8'h0F, 1'b0},
      {8'h3C, 8'h24, 1'b1},
      {8'hFF, 8'h00, 1'b0},
      {8'h55, 8'hAA, 1'b0},
      {8'h55, 8'h41, 1'b1}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              inst_sync = 1'b0;
   logic              test_dec = 1'b0;
   logic [UNIT_W-1:0] unit_sel = '0;
   logic              data_here = 1'b0;
   logic [DATA_W-1:0] io_word = '0;
   logic [FUNC_W-1:0] cond = '0;
   logic              sync_ret, test_ret, data_ack;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   ptr_test_responder #(
      .UNIT_W  (UNIT_W),
      .UNIT_ID (UNIT_ID),
      .DATA_W  (DATA_W),
      .FUNC_W  (FUNC_W),
      .FUNC_LSB(0)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .inst_sync_i (inst_sync),
      .test_dec_i  (test_dec),
      .unit_sel_i  (unit_sel),
      .data_here_i (data_here),
      .io_word_i   (io_word),
      .cond_i      (cond),
      .sync_ret_o  (sync_ret),
      .test_ret_o  (test_ret),
      .data_ack_o  (data_ack)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic do_sync(input logic [UNIT_W-1:0] u, input logic dec);
      inst_sync = 1'b1; test_dec = dec; unit_sel = u;
      tick();
   endtask

   task automatic end_sync();
      inst_sync = 1'b0;
      tick();
   endtask

   initial begin
      repeat (4000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // R1: reset state
      chk("R1 sync_ret", sync_ret, 1'b0);
      chk("R1 test_ret", test_ret, 1'b0);
      chk("R1 data_ack", data_ack, 1'b0);
      tick();
      rst_n = 1'b1;
      tick();

      for (int k = 0; k < NVEC; k++) begin
         do_sync(UNIT_ID[UNIT_W-1:0], 1'b1);
         chk("R2 sync return", sync_ret, 1'b1);
         end_sync();
         chk("R4 sync drop", sync_ret, 1'b0);
         io_word   = {8'hA5, VEC[k][16:9]};
         cond      = VEC[k][8:1];
         data_here = 1'b1;
         tick();
         chk("R5 data_ack", data_ack, 1'b1);
         chk("R6 test_ret", test_ret, VEC[k][0]);
         data_here = 1'b0;
         tick();
         chk("R7 data_ack clear", data_ack, 1'b0);
         chk("R7 test_ret clear", test_ret, 1'b0);
      end

      // R3: wrong unit, then missing test decode
      do_sync(UNIT_ID[UNIT_W-1:0] ^ 6'd1, 1'b1);
      chk("R3 wrong unit", sync_ret, 1'b0);
      end_sync();
      do_sync(UNIT_ID[UNIT_W-1:0], 1'b0);
      chk("R3 no decode", sync_ret, 1'b0);
      end_sync();

      // R10: data-here with no handshake (after the failed syncs above)
      io_word = 16'h00FF; cond = 8'hFF; data_here = 1'b1;
      tick();
      chk("R10 data_ack", data_ack, 1'b0);
      chk("R10 test_ret", test_ret, 1'b0);
      data_here = 1'b0;
      tick();

      // R9 and R8: capture on first edge, hold while strobe stays
      do_sync(UNIT_ID[UNIT_W-1:0], 1'b1);
      end_sync();
      io_word = 16'h0010; cond = 8'h10; data_here = 1'b1;
      tick();
      chk("R8 ack with test", data_ack, 1'b1);
      chk("R6 match", test_ret, 1'b1);
      cond = 8'h00; io_word = 16'h0000;
      tick();
      chk("R9 held result", test_ret, 1'b1);
      data_here = 1'b0;
      tick();
      chk("R7 clear after hold", test_ret, 1'b0);

      // R11: a second data-here without a new sync is ignored
      io_word = 16'h00FF; cond = 8'hFF; data_here = 1'b1;
      tick();
      chk("R11 data_ack", data_ack, 1'b0);
      chk("R11 test_ret", test_ret, 1'b0);
      data_here = 1'b0;
      tick();

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule